// File: doc/BRIEF.md
# Serial-Memory Register Configuration Loader

After reset, or on request, this block walks a configuration image held in a byte-wide serial memory. It writes the register values found there into on-chip configuration registers. It fetches one byte at a time through a request/valid handshake. The memory-side protocol engine sits outside the block.

The image starts with a tag byte of A5h. If the tag is wrong, the image is treated as absent. The tag is followed by a burst count. Each burst has a two-byte header: the high byte is a 32-bit-word register index and the low byte is a word count. The words follow the header, each sent most significant byte first.

Every assembled word goes out on a register write port. A write is only issued once two external busy inputs are both idle: one from the switch register interface and one from the PHY management interface. A two-bit size strap sets how far into the memory the loader may read. If parsing would need a byte beyond that limit, the loader stops and holds an overflow flag. Otherwise it finishes and holds a done flag.

Top module: `cfg_image_loader`

## Requirements
- R1: If memory byte 0 is not A5h, the loader performs no register write and goes to the finished state (busy 0, done 1, overflow 0).
- R2: Byte 1 is the number of bursts (0 to 255) and exactly that many bursts are parsed; a value of 0 finishes with no writes.
- R3: In each two-byte burst header, the first byte D gives the word index, and the first register write of the burst goes to byte address {D, 2'b00} on the 10-bit write address. The second byte is the number of 32-bit words in the burst.
- R4: Each word is taken from four consecutive memory bytes, the first byte becoming bits [31:24] and the last bits [7:0].
- R5: Successive words of a burst go to addresses 4 apart, with the 8-bit word index wrapping from FFh to 00h. A burst with a word count of 0 writes nothing, and parsing continues with the next header.
- R6: A write pulse (wr_en_o high for exactly one cycle) is issued only in the cycle after one in which both csr_busy_i and pmi_busy_i were low; while either stays high, no write is issued.
- R7: The byte limit is 128, 2048, 16384 or 65536 for size_sel_i = 0, 1, 2, 3. The loader never requests an address at or beyond the limit. When parsing needs such a byte, it stops with busy 0, done 0 and overflow 1, and the overflow flag stays set until the next accepted start. Words whose four bytes were all read before the stop are still written.
- R8: Once every burst has been processed, busy falls, done rises, and no further memory requests or writes occur until the next start.
- R9: A start pulse while not busy restarts parsing from memory byte 0, clears done and overflow, and makes busy high in the following cycle; a start pulse while busy has no effect.
- R10: During and right after reset, busy, done, overflow, rom_req_o and wr_en_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start or reload request, one-cycle pulse |
| size_sel_i | input | 2 | Memory size strap selecting the byte limit |
| rom_req_o | output | 1 | Byte read request, held until rom_vld_i |
| rom_addr_o | output | 16 | Byte address of the pending read |
| rom_data_i | input | 8 | Returned byte |
| rom_vld_i | input | 1 | Returned byte is valid this cycle |
| csr_busy_i | input | 1 | Switch register interface busy |
| pmi_busy_i | input | 1 | PHY management interface busy |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | 10 | Register byte address |
| wr_data_o | output | 32 | Register write data |
| busy_o | output | 1 | Loader is parsing |
| done_o | output | 1 | Loader finished normally |
| ovf_o | output | 1 | Loader stopped on the size limit |

## Verification
A byte is consumed at the clock edge where rom_vld_i meets rom_req_o. The write pulse appears one cycle after the edge that saw both busy inputs low. The bench drives all inputs on the falling edge and records each write at the falling edge inside its pulse, where the busy values it drove for the preceding rising edge are still in place. Busy rises one cycle after an accepted start, and the bench checks it at the next falling edge. Done and overflow settle at the edge where busy falls, so the bench compares the recorded writes and both flags once it sees busy low. It then watches several more idle cycles for stray requests or writes.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;

  localparam logic [7:0] IMAGE_TAG = 8'hA5;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FLAG,
    S_NBURST,
    S_HDR_HI,
    S_HDR_LO,
    S_DATA,
    S_WRITE,
    S_DONE,
    S_HALT
  } ldr_state_e;

  // Highest byte count allowed for each strap setting.
  function automatic int unsigned rom_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32'd1 << 7;
      2'd1:    return 32'd1 << 11;
      2'd2:    return 32'd1 << 14;
      default: return 32'd1 << 16;
    endcase
  endfunction

endpackage

// File: rtl/cfg_ldr_fetch.sv
module cfg_ldr_fetch
  import cfg_ldr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic          want_i,
  input  logic [1:0]    size_sel_i,
  input  logic          rom_vld_i,
  output logic          rom_req_o,
  output logic [AW-1:0] rom_addr_o,
  output logic          over_o,
  output logic          take_o
);

  logic [AW:0] ptr;
  logic        beyond;

  assign beyond     = 32'(ptr) >= rom_limit(size_sel_i);
  assign rom_req_o  = want_i & ~beyond;
  assign over_o     = want_i & beyond;
  assign take_o     = rom_req_o & rom_vld_i;
  assign rom_addr_o = ptr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr <= '0;
    else if (restart_i) ptr <= '0;
    else if (take_o)    ptr <= ptr + 1'b1;
  end

endmodule

// File: rtl/cfg_ldr_pack.sv
module cfg_ldr_pack #(
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            vld_i,
  input  logic [7:0]      byte_i,
  output logic            full_o,
  output logic [8*NB-1:0] word_o
);

  localparam int CW = (NB > 1) ? $clog2(NB) : 1;

  logic [CW-1:0]     cnt;
  logic [8*NB-9:0]   acc;
  logic              last;

  assign last   = (cnt == CW'(NB - 1));
  assign full_o = vld_i & last;
  assign word_o = {acc, byte_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      acc <= '0;
    end else if (clear_i) begin
      cnt <= '0;
    end else if (vld_i) begin
      acc <= word_o[8*NB-9:0];
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/cfg_ldr_wgate.sv
module cfg_ldr_wgate #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          csr_busy_i,
  input  logic          pmi_busy_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);

  logic pend;
  logic fire;

  assign fire = pend & ~csr_busy_i & ~pmi_busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= fire;
      if (load_i) begin
        pend      <= 1'b1;
        wr_addr_o <= addr_i;
        wr_data_o <= data_i;
      end else if (fire) begin
        pend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
  import cfg_ldr_pkg::*;
#(
  parameter int ROM_AW     = 16,
  parameter int REG_AW     = 10,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [1:0]              size_sel_i,
  output logic                    rom_req_o,
  output logic [ROM_AW-1:0]       rom_addr_o,
  input  logic [7:0]              rom_data_i,
  input  logic                    rom_vld_i,
  input  logic                    csr_busy_i,
  input  logic                    pmi_busy_i,
  output logic                    wr_en_o,
  output logic [REG_AW-1:0]       wr_addr_o,
  output logic [8*WORD_BYTES-1:0] wr_data_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    ovf_o
);

  localparam int DW  = 8 * WORD_BYTES;
  localparam int SH  = $clog2(WORD_BYTES);
  localparam int DWA = REG_AW - SH;

  ldr_state_e       state;
  logic [7:0]       bursts_left;
  logic [7:0]       words_left;
  logic [DWA-1:0]   dw_addr;

  // Named internal events
  logic             ev_start;
  logic             ev_take;
  logic             ev_over;
  logic             ev_word_full;
  logic             want;
  logic [DW-1:0]    word;

  assign busy_o   = !(state inside {S_IDLE, S_DONE, S_HALT});
  assign done_o   = (state == S_DONE);
  assign ovf_o    = (state == S_HALT);
  assign ev_start = start_i & ~busy_o;
  assign want     = state inside {S_FLAG, S_NBURST, S_HDR_HI, S_HDR_LO, S_DATA};

  cfg_ldr_fetch #(.AW(ROM_AW)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (ev_start),
    .want_i     (want),
    .size_sel_i (size_sel_i),
    .rom_vld_i  (rom_vld_i),
    .rom_req_o  (rom_req_o),
    .rom_addr_o (rom_addr_o),
    .over_o     (ev_over),
    .take_o     (ev_take)
  );

  cfg_ldr_pack #(.NB(WORD_BYTES)) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (ev_start),
    .vld_i   (ev_take && state == S_DATA),
    .byte_i  (rom_data_i),
    .full_o  (ev_word_full),
    .word_o  (word)
  );

  cfg_ldr_wgate #(.AW(REG_AW), .DW(DW)) u_wgate (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ev_word_full),
    .addr_i     ({dw_addr, {SH{1'b0}}}),
    .data_i     (word),
    .csr_busy_i (csr_busy_i),
    .pmi_busy_i (pmi_busy_i),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      bursts_left <= '0;
      words_left  <= '0;
      dw_addr     <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE, S_HALT: begin
          if (start_i) state <= S_FLAG;
        end
        S_WRITE: begin
          if (wr_en_o) begin
            dw_addr <= dw_addr + 1'b1;
            if (words_left == 8'd1) begin
              if (bursts_left == 8'd1) state <= S_DONE;
              else begin
                bursts_left <= bursts_left - 8'd1;
                state       <= S_HDR_HI;
              end
            end else begin
              words_left <= words_left - 8'd1;
              state      <= S_DATA;
            end
          end
        end
        default: begin
          if (ev_over) begin
            state <= S_HALT;
          end else if (ev_take) begin
            case (state)
              S_FLAG:   state <= (rom_data_i == IMAGE_TAG) ? S_NBURST : S_DONE;
              S_NBURST: begin
                bursts_left <= rom_data_i;
                state       <= (rom_data_i == 8'd0) ? S_DONE : S_HDR_HI;
              end
              S_HDR_HI: begin
                dw_addr <= DWA'(rom_data_i);
                state   <= S_HDR_LO;
              end
              S_HDR_LO: begin
                words_left <= rom_data_i;
                if (rom_data_i != 8'd0) state <= S_DATA;
                else if (bursts_left == 8'd1) state <= S_DONE;
                else begin
                  bursts_left <= bursts_left - 8'd1;
                  state       <= S_HDR_HI;
                end
              end
              S_DATA:   if (ev_word_full) state <= S_WRITE;
              default:  ;
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/cfg_ldr_checker.sv
module cfg_ldr_checker
  import cfg_ldr_pkg::*;
#(
  parameter int ROM_AW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [1:0]        size_sel_i,
  input logic              rom_req_o,
  input logic [ROM_AW-1:0] rom_addr_o,
  input logic              csr_busy_i,
  input logic              pmi_busy_i,
  input logic              wr_en_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              ovf_o,
  input logic              ev_over
);

  assert_write_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(!csr_busy_i && !pmi_busy_i));

  assert_write_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);

  assert_req_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req_o |-> (32'(rom_addr_o) < rom_limit(size_sel_i)));

  assert_over_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_over |=> (ovf_o && !busy_o && !done_o));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_o) |-> $past(start_i));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!rom_req_o && !wr_en_o));

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && ovf_o));

  assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !done_o && !ovf_o));

endmodule

bind cfg_image_loader cfg_ldr_checker #(.ROM_AW(ROM_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .size_sel_i (size_sel_i),
  .rom_req_o  (rom_req_o),
  .rom_addr_o (rom_addr_o),
  .csr_busy_i (csr_busy_i),
  .pmi_busy_i (pmi_busy_i),
  .wr_en_o    (wr_en_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .ovf_o      (ovf_o),
  .ev_over    (ev_over)
);

// File: tb/sim_cfg_image_loader.sv
module sim_cfg_image_loader;

  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        start_i = 0;
  logic [1:0]  size_sel_i = 0;
  logic        rom_req_o;
  logic [15:0] rom_addr_o;
  logic [7:0]  rom_data_i = 0;
  logic        rom_vld_i = 0;
  logic        csr_busy_i = 0;
  logic        pmi_busy_i = 0;
  logic        wr_en_o;
  logic [9:0]  wr_addr_o;
  logic [31:0] wr_data_o;
  logic        busy_o, done_o, ovf_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_image_loader u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_sel_i(size_sel_i),
    .rom_req_o(rom_req_o), .rom_addr_o(rom_addr_o), .rom_data_i(rom_data_i),
    .rom_vld_i(rom_vld_i), .csr_busy_i(csr_busy_i), .pmi_busy_i(pmi_busy_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .busy_o(busy_o), .done_o(done_o), .ovf_o(ovf_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int busy_mode = 2;   // 0 random, 1 held high, 2 held low
  int wp;
  logic [7:0]  mem [0:4095];
  logic [9:0]  ea[$];
  logic [31:0] ed[$];
  logic [9:0]  ca[$];
  logic [31:0] cd[$];
  bit e_done, e_ovf;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_rd(input int a);
    return (a < 4096) ? mem[a] : 8'h00;
  endfunction

  function automatic int lim_of(input logic [1:0] sel);
    case (sel)
      2'd0: return 128;
      2'd1: return 2048;
      2'd2: return 16384;
      default: return 65536;
    endcase
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    wp = 0;
  endtask

  task automatic emit(input logic [7:0] b);
    mem[wp] = b;
    wp++;
  endtask

  task automatic rd(inout int p, input int lim, output logic [7:0] b, output bit ok);
    if (p >= lim) begin ok = 0; b = 0; end
    else begin ok = 1; b = mem_rd(p); p++; end
  endtask

  // Independent expectation from the requirements
  task automatic model(input int lim);
    int p;
    logic [7:0] b, nb, hi, lo;
    logic [31:0] w;
    bit ok;
    ea.delete(); ed.delete(); e_done = 0; e_ovf = 0; p = 0;
    rd(p, lim, b, ok); if (!ok) begin e_ovf = 1; return; end
    if (b != 8'hA5) begin e_done = 1; return; end
    rd(p, lim, nb, ok); if (!ok) begin e_ovf = 1; return; end
    for (int k = 0; k < int'(nb); k++) begin
      rd(p, lim, hi, ok); if (!ok) begin e_ovf = 1; return; end
      rd(p, lim, lo, ok); if (!ok) begin e_ovf = 1; return; end
      for (int j = 0; j < int'(lo); j++) begin
        w = 0;
        for (int q = 0; q < 4; q++) begin
          rd(p, lim, b, ok); if (!ok) begin e_ovf = 1; return; end
          w = {w[23:0], b};
        end
        ea.push_back({hi + 8'(j), 2'b00});
        ed.push_back(w);
      end
    end
    e_done = 1;
  endtask

  // Memory responder, busy driver and write recorder
  initial begin
    int lat;
    lat = -1;
    forever begin
      @(negedge clk);
      if (wr_en_o) begin
        ca.push_back(wr_addr_o);
        cd.push_back(wr_data_o);
        chk(!csr_busy_i && !pmi_busy_i, "R6", "write while busy",
            {csr_busy_i, pmi_busy_i}, 0);
      end
      if (rom_vld_i) begin
        rom_vld_i = 0;
        lat = -1;
      end else if (rom_req_o) begin
        if (lat < 0) lat = $urandom_range(0, 2);
        if (lat == 0) begin
          rom_vld_i  = 1;
          rom_data_i = mem_rd(int'(rom_addr_o));
        end else lat--;
      end else lat = -1;
      case (busy_mode)
        0: begin
          csr_busy_i = ($urandom_range(0, 3) == 0);
          pmi_busy_i = ($urandom_range(0, 4) == 0);
        end
        1: begin csr_busy_i = 1; pmi_busy_i = 1; end
        default: begin csr_busy_i = 0; pmi_busy_i = 0; end
      endcase
    end
  end

  task automatic run(input string req, input logic [1:0] sel,
                     input int hold, input bit restart_mid);
    int reqs;
    int nw;
    size_sel_i = sel;
    model(lim_of(sel));
    ca.delete(); cd.delete();
    if (hold > 0) busy_mode = 1;
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    chk(busy_o && !done_o && !ovf_o, "R9", "busy after start",
        {busy_o, done_o, ovf_o}, 3'b100);
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk(ca.size() == 0, "R6", "writes while busy held", ca.size(), 0);
      busy_mode = 0;
    end
    if (restart_mid) begin
      repeat (5) @(negedge clk);
      start_i = 1;
      @(negedge clk); start_i = 0;
    end
    while (busy_o) @(negedge clk);
    chk(ca.size() == ea.size(), req, "write count", ca.size(), ea.size());
    for (int i = 0; i < ea.size() && i < ca.size(); i++) begin
      chk(ca[i] == ea[i], "R3/R5", "write address", ca[i], ea[i]);
      chk(cd[i] == ed[i], "R4", "write data", cd[i], ed[i]);
    end
    chk(done_o == e_done, "R8", "done flag", done_o, e_done);
    chk(ovf_o == e_ovf, "R7", "overflow flag", ovf_o, e_ovf);
    nw = ca.size();
    reqs = 0;
    repeat (8) begin
      @(negedge clk);
      if (rom_req_o) reqs++;
    end
    chk(reqs == 0 && ca.size() == nw, "R8", "quiet after finish", reqs, 0);
    chk(ovf_o == e_ovf, "R7", "overflow sticky", ovf_o, e_ovf);
  endtask

  task automatic rand_image();
    int nb;
    clear_mem();
    emit(($urandom_range(0, 7) == 0) ? 8'($urandom_range(0, 255)) : 8'hA5);
    nb = $urandom_range(0, 4);
    emit(8'(nb));
    for (int k = 0; k < nb; k++) begin
      int cnt;
      cnt = $urandom_range(0, 5);
      emit(8'($urandom_range(0, 255)));
      emit(8'(cnt));
      for (int j = 0; j < 4 * cnt; j++) emit(8'($urandom_range(0, 255)));
    end
  endtask

  task automatic big_image();
    clear_mem();
    emit(8'hA5); emit(8'd3);
    for (int k = 0; k < 3; k++) begin
      emit(8'(16 * k)); emit(8'd200);
      for (int j = 0; j < 800; j++) emit(8'(j * 7 + k));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    clear_mem();
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!busy_o && !done_o && !ovf_o && !rom_req_o && !wr_en_o, "R10", "reset outputs",
        {busy_o, done_o, ovf_o, rom_req_o, wr_en_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy_o && !done_o && !ovf_o && !rom_req_o && !wr_en_o, "R10", "after reset",
        {busy_o, done_o, ovf_o, rom_req_o, wr_en_o}, 0);
    busy_mode = 0;

    // Example image: 1, 2, 3 words at 40h, 80h, C0h (R3, R4, R5)
    clear_mem();
    emit(8'hA5); emit(8'h03);
    emit(8'h10); emit(8'h01);
    for (int i = 0; i < 4; i++)  emit(8'h11 + 8'(i));
    emit(8'h20); emit(8'h02);
    for (int i = 0; i < 8; i++)  emit(8'h21 + 8'(i));
    emit(8'h30); emit(8'h03);
    for (int i = 0; i < 12; i++) emit(8'h31 + 8'(i));
    run("R2", 2'd1, 0, 0);
    chk(ca.size() == 6, "R2", "example writes", ca.size(), 6);
    chk(ca[0] == 10'h040 && cd[0] == 32'h11121314, "R3", "first write", cd[0], 32'h11121314);
    chk(ca[2] == 10'h084 && cd[2] == 32'h25262728, "R5", "second word of burst", ca[2], 10'h084);
    chk(ca[3] == 10'h0C0, "R3", "third burst base", ca[3], 10'h0C0);

    // Bad tag (R1)
    clear_mem(); emit(8'h5A); emit(8'h02); emit(8'h01); emit(8'h01);
    run("R1", 2'd1, 0, 0);
    chk(ca.size() == 0 && done_o, "R1", "no writes on bad tag", ca.size(), 0);

    // Zero bursts (R2)
    clear_mem(); emit(8'hA5); emit(8'h00);
    run("R2", 2'd2, 0, 0);
    chk(ca.size() == 0 && done_o, "R2", "zero bursts", ca.size(), 0);

    // Zero-count burst and index wrap (R5)
    clear_mem(); emit(8'hA5); emit(8'h03);
    emit(8'h22); emit(8'h00);
    emit(8'hFF); emit(8'h02);
    for (int i = 0; i < 8; i++) emit(8'hC0 + 8'(i));
    emit(8'h05); emit(8'h00);
    run("R5", 2'd3, 0, 0);
    chk(ca.size() == 2 && ca[0] == 10'h3FC && ca[1] == 10'h000, "R5", "wrap",
        ca[1], 10'h000);

    // Overflow at 128-byte limit (R7)
    clear_mem(); emit(8'hA5); emit(8'h01); emit(8'h00); emit(8'h40);
    for (int i = 0; i < 256; i++) emit(8'(i));
    run("R7", 2'd0, 0, 0);
    chk(ovf_o && !done_o && ca.size() == 31, "R7", "partial writes before stop", ca.size(), 31);

    // Restart after overflow clears flag (R9)
    clear_mem(); emit(8'hA5); emit(8'h01); emit(8'h08); emit(8'h01);
    emit(8'hDE); emit(8'hAD); emit(8'hBE); emit(8'hEF);
    run("R9", 2'd0, 0, 0);
    chk(!ovf_o && done_o && cd[0] == 32'hDEADBEEF, "R9", "rerun after overflow", cd[0], 32'hDEADBEEF);

    // Busy inputs held high (R6)
    run("R6", 2'd1, 40, 0);

    // Large image: overflow at 2048, then full at 16384; start while busy ignored (R9)
    big_image();
    run("R7", 2'd1, 0, 1);
    chk(ca.size() == 510, "R7", "writes below 2048 limit", ca.size(), 510);
    run("R9", 2'd2, 0, 1);
    chk(ca.size() == 600 && done_o, "R9", "mid-run start ignored", ca.size(), 600);

    // Random images
    for (int t = 0; t < 24; t++) begin
      rand_image();
      run("R2", 2'($urandom_range(1, 3)), 0, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule